// File: doc/BRIEF.md
# Oversampled Serial Receiver with Address Filter

This block recovers characters from an asynchronous serial line. A baud tick input pulses once per oversample period: sixteen per bit normally, eight per bit in double-speed mode. The receiver synchronizes the line into the clock domain and looks for a start bit. It then decides every bit by majority vote of three samples around the bit centre and assembles frames of 5 to 9 data bits. A frame may carry an optional even or odd parity bit and has one or two stop bits.

Each finished frame goes into a two-entry receive buffer, together with its frame-error and parity-error flags. A per-entry overrun flag marks the entry that was stored last before a frame was lost. In address-filter mode, frames whose type bit is zero are thrown away before they reach the buffer. The host reads the head entry through a read port and pops it with a one-cycle read strobe. An interrupt output stays high while unread data is present.

Top module: `uart_addr_rx`

## Requirements
- R1: `size_sel` selects the data bits per frame: 0, 1, 2 and 3 give 5, 6, 7 and 8 bits, and any value from 4 to 7 gives 9 bits. Data arrives LSB first and is right-justified on `{rd_bit9, rd_data}`, with unused upper bits read as zero.
- R2: In normal speed a bit lasts 16 ticks. A start is armed by a low line on a tick in idle. Every bit, including the start bit, is decided by the majority of its 7th, 8th and 9th samples, and a start whose majority is high is rejected without storing anything.
- R3: With `dbl_speed` high a bit lasts 8 ticks and the vote uses its 3rd, 4th and 5th samples.
- R4: `par_mode` 0 or 1 means no parity bit, 2 means even parity and 3 means odd parity. A mismatching parity bit sets `rd_parity_err` on that entry.
- R5: A low first stop bit sets `rd_frame_err` on that entry. With `two_stop` high the second stop bit is waited out but never checked.
- R6: The buffer holds two entries, read in arrival order. `rx_valid` is high while at least one is unread, and `rd_en` pops the head.
- R7: A frame that completes while both entries are full and nothing is being read is dropped. This sets `rd_overrun` on the most recently stored entry, and the buffer contents are otherwise unchanged.
- R8: While `rx_en` is low the buffer is flushed, `rx_valid` is low and the line is ignored.
- R9: With `addr_filter` high only frames whose type bit is one are stored. The type bit is the first stop bit for 5 to 8 data bits and the ninth data bit for 9 data bits.
- R10: `rx_irq` is high when `irq_en` is high and unread data exists. It stays high until the data is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receiver enable; low flushes the buffer |
| baud_tick | input | 1 | One-cycle pulse per oversample period |
| dbl_speed | input | 1 | Eight samples per bit instead of sixteen |
| size_sel | input | 3 | Data-bit count select |
| par_mode | input | 2 | Parity: none, even (2) or odd (3) |
| two_stop | input | 1 | Two stop bits per frame |
| addr_filter | input | 1 | Store address frames only |
| irq_en | input | 1 | Interrupt enable |
| rx_line | input | 1 | Serial input, idle high |
| rd_en | input | 1 | Pop the head entry |
| rd_data | output | 8 | Head entry, data bits 7..0 |
| rd_bit9 | output | 1 | Head entry, ninth data bit |
| rd_frame_err | output | 1 | Head entry stop bit was low |
| rd_parity_err | output | 1 | Head entry parity mismatch |
| rd_overrun | output | 1 | A frame was lost after the head entry |
| rx_valid | output | 1 | Unread data present |
| rx_irq | output | 1 | Receive interrupt |

## Verification
The bench uses the default parameters: a 16x ratio, a two-entry buffer and a two-stage synchronizer. The tick comes every fourth clock, so a bit spans 64 clocks, or 32 at double speed. With the buffer only two deep, a third unread frame reaches the overrun path after two frames. Bad stop bits are driven low only for the first three quarters of the bit. The receiver then sees a short low in idle, which exercises the false-start rejection of the majority vote on the same run.

// File: rtl/uarx_pkg.sv
package uarx_pkg;
  localparam int unsigned MAXBITS = 9;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP1, S_STOP2
  } rx_state_t;

  typedef struct packed {
    logic               fe;
    logic               pe;
    logic [MAXBITS-1:0] data;
  } rx_entry_t;

  // data-bit count from the size select: 0..3 -> 5..8, 4..7 -> 9
  function automatic logic [3:0] bits_of(input logic [2:0] sel);
    return sel[2] ? 4'd9 : ({2'b00, sel[1:0]} + 4'd5);
  endfunction
endpackage

// File: rtl/uarx_sync.sv
module uarx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/uarx_frame.sv
module uarx_frame
  import uarx_pkg::*;
#(
  parameter int unsigned OSR = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               tick,
  input  logic               rx_s,
  input  logic               dbl,
  input  logic [2:0]         size_sel,
  input  logic [1:0]         par_mode,
  input  logic               two_stop,
  input  logic               mpc,
  output logic               push_o,
  output logic [MAXBITS-1:0] data_o,
  output logic               fe_o,
  output logic               pe_o
);
  localparam int unsigned CW = $clog2(OSR);
  localparam logic [CW-1:0] LAST_N = CW'(OSR - 1);
  localparam logic [CW-1:0] LAST_D = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] MID_N  = CW'(OSR / 2);
  localparam logic [CW-1:0] MID_D  = CW'(OSR / 4);

  rx_state_t          state;
  logic [CW-1:0]      cnt;
  logic [3:0]         bitn;
  logic [MAXBITS-1:0] sh;
  logic               px, pbit, v0, v1;

  logic [CW-1:0]      mid, last, va, vb;
  logic [3:0]         nbits;
  logic               maj, par_en, type_w, par_err;
  logic [MAXBITS-1:0] word;

  always_comb begin
    mid     = dbl ? MID_D : MID_N;
    last    = dbl ? LAST_D : LAST_N;
    va      = mid - CW'(2);
    vb      = mid - CW'(1);
    nbits   = bits_of(size_sel);
    maj     = (v0 & v1) | (v0 & rx_s) | (v1 & rx_s);
    par_en  = par_mode[1];
    word    = sh >> (4'd9 - nbits);
    type_w  = (nbits == 4'd9) ? word[8] : maj;
    par_err = par_en & (px ^ pbit ^ par_mode[0]);
  end

  always_ff @(posedge clk) begin
    push_o <= 1'b0;
    if (rst || !en) begin
      state  <= S_IDLE;
      cnt    <= '0;
      bitn   <= '0;
      sh     <= '0;
      px     <= 1'b0;
      pbit   <= 1'b0;
      v0     <= 1'b1;
      v1     <= 1'b1;
      data_o <= '0;
      fe_o   <= 1'b0;
      pe_o   <= 1'b0;
    end else if (tick) begin
      if (state == S_IDLE) begin
        if (!rx_s) begin
          state <= S_START;
          cnt   <= CW'(1);
        end
      end else begin
        if (cnt == va) v0 <= rx_s;
        if (cnt == vb) v1 <= rx_s;
        if (cnt == last) cnt <= '0;
        else             cnt <= cnt + CW'(1);

        if (cnt == mid) begin
          case (state)
            S_START: if (maj) state <= S_IDLE;
            S_DATA: begin
              sh   <= {maj, sh[MAXBITS-1:1]};
              px   <= px ^ maj;
              bitn <= bitn + 4'd1;
            end
            S_PAR:   pbit <= maj;
            S_STOP1: begin
              push_o <= !(mpc && !type_w);
              data_o <= word;
              fe_o   <= !maj;
              pe_o   <= par_err;
              if (!two_stop) state <= S_IDLE;
            end
            S_STOP2: state <= S_IDLE;
            default: ;
          endcase
        end else if (cnt == last) begin
          case (state)
            S_START: begin
              state <= S_DATA;
              bitn  <= '0;
              px    <= 1'b0;
            end
            S_DATA:  if (bitn == nbits) state <= par_en ? S_PAR : S_STOP1;
            S_PAR:   state <= S_STOP1;
            S_STOP1: state <= S_STOP2;
            default: ;
          endcase
        end
      end
    end
  end

  // R2: a high line in idle never arms the receiver
  a_r2_idle_needs_low: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && tick && en && rx_s) |=> (state == S_IDLE));

  // R6: a frame is handed over for exactly one cycle
  a_r6_push_pulse: assert property (@(posedge clk) disable iff (rst)
    push_o |=> !push_o);
endmodule

// File: rtl/uarx_buf.sv
module uarx_buf
  import uarx_pkg::*;
#(
  parameter int unsigned DEPTH = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      en,
  input  logic      push,
  input  rx_entry_t wr_entry,
  input  logic      pop,
  output rx_entry_t rd_entry,
  output logic      rd_ovr,
  output logic      not_empty
);
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNTW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0]   LASTP = PW'(DEPTH - 1);
  localparam logic [CNTW-1:0] FULL  = CNTW'(DEPTH);

  rx_entry_t        mem [DEPTH];
  logic [DEPTH-1:0] ovr;
  logic [PW-1:0]    wr_p, rd_p;
  logic [CNTW-1:0]  cnt;
  logic             full, do_pop, do_push, lost;

  function automatic logic [PW-1:0] p_next(input logic [PW-1:0] p);
    return (p == LASTP) ? '0 : p + PW'(1);
  endfunction

  function automatic logic [PW-1:0] p_prev(input logic [PW-1:0] p);
    return (p == '0) ? LASTP : p - PW'(1);
  endfunction

  always_comb begin
    full    = (cnt == FULL);
    do_pop  = pop && (cnt != '0);
    do_push = push && (!full || do_pop);
    lost    = push && full && !do_pop;
  end

  // storage: single write port, no reset
  always_ff @(posedge clk) begin
    if (en && do_push) mem[wr_p] <= wr_entry;
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      wr_p <= '0;
      rd_p <= '0;
      cnt  <= '0;
      ovr  <= '0;
    end else begin
      if (do_push) begin
        wr_p       <= p_next(wr_p);
        ovr[wr_p]  <= 1'b0;
      end
      if (do_pop) rd_p <= p_next(rd_p);
      if (lost) ovr[p_prev(wr_p)] <= 1'b1;
      if (do_push && !do_pop)      cnt <= cnt + CNTW'(1);
      else if (do_pop && !do_push) cnt <= cnt - CNTW'(1);
    end
  end

  assign rd_entry  = mem[rd_p];
  assign rd_ovr    = ovr[rd_p];
  assign not_empty = (cnt != '0);

  // R6: occupancy never exceeds the depth
  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL);

  // R8: a disabled receiver holds nothing
  a_r8_flush: assert property (@(posedge clk) disable iff (rst)
    !en |=> (cnt == '0));

  // R7: a frame arriving at a full buffer does not change occupancy
  a_r7_full_keeps: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop && en) |=> full);
endmodule

// File: rtl/uart_addr_rx.sv
module uart_addr_rx
  import uarx_pkg::*;
#(
  parameter int unsigned OSR        = 16,
  parameter int unsigned DEPTH      = 2,
  parameter int unsigned SYNC_STAGE = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_en,
  input  logic       baud_tick,
  input  logic       dbl_speed,
  input  logic [2:0] size_sel,
  input  logic [1:0] par_mode,
  input  logic       two_stop,
  input  logic       addr_filter,
  input  logic       irq_en,
  input  logic       rx_line,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  output logic       rd_bit9,
  output logic       rd_frame_err,
  output logic       rd_parity_err,
  output logic       rd_overrun,
  output logic       rx_valid,
  output logic       rx_irq
);
  logic               rx_s, push, fe, pe;
  logic [MAXBITS-1:0] fdata;
  rx_entry_t          wr_e, head;

  uarx_sync #(.STAGES(SYNC_STAGE)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (rx_line),
    .q   (rx_s)
  );

  uarx_frame #(.OSR(OSR)) u_frame (
    .clk      (clk),
    .rst      (rst),
    .en       (rx_en),
    .tick     (baud_tick),
    .rx_s     (rx_s),
    .dbl      (dbl_speed),
    .size_sel (size_sel),
    .par_mode (par_mode),
    .two_stop (two_stop),
    .mpc      (addr_filter),
    .push_o   (push),
    .data_o   (fdata),
    .fe_o     (fe),
    .pe_o     (pe)
  );

  assign wr_e = '{fe: fe, pe: pe, data: fdata};

  uarx_buf #(.DEPTH(DEPTH)) u_buf (
    .clk       (clk),
    .rst       (rst),
    .en        (rx_en),
    .push      (push),
    .wr_entry  (wr_e),
    .pop       (rd_en),
    .rd_entry  (head),
    .rd_ovr    (rd_overrun),
    .not_empty (rx_valid)
  );

  assign rd_data       = head.data[7:0];
  assign rd_bit9       = head.data[8];
  assign rd_frame_err  = head.fe;
  assign rd_parity_err = head.pe;
  assign rx_irq        = irq_en && rx_valid;

  // R6 / R10: unread data stays visible until it is read or flushed
  a_r6_valid_holds: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rd_en && rx_en) |=> rx_valid);
endmodule

// File: tb/sim_uart_addr_rx.sv
module sim_uart_addr_rx;
  localparam int CLK_PERIOD = 10;
  localparam int TDIV       = 4;

  logic       clk = 0, rst = 1, rx_en = 1, baud_tick = 0, dbl_speed = 0;
  logic [2:0] size_sel = 3'd3;
  logic [1:0] par_mode = 2'd0;
  logic       two_stop = 0, addr_filter = 0, irq_en = 0, rx_line = 1, rd_en = 0;
  logic [7:0] rd_data;
  logic       rd_bit9, rd_frame_err, rd_parity_err, rd_overrun, rx_valid, rx_irq;
  int checks = 0, errors = 0;

  uart_addr_rx u0 (
    .clk(clk), .rst(rst), .rx_en(rx_en), .baud_tick(baud_tick),
    .dbl_speed(dbl_speed), .size_sel(size_sel), .par_mode(par_mode),
    .two_stop(two_stop), .addr_filter(addr_filter), .irq_en(irq_en),
    .rx_line(rx_line), .rd_en(rd_en), .rd_data(rd_data), .rd_bit9(rd_bit9),
    .rd_frame_err(rd_frame_err), .rd_parity_err(rd_parity_err),
    .rd_overrun(rd_overrun), .rx_valid(rx_valid), .rx_irq(rx_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    forever begin
      repeat (TDIV - 1) @(negedge clk);
      baud_tick = 1;
      @(negedge clk);
      baud_tick = 0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int bit_clks();
    return (dbl_speed ? 8 : 16) * TDIV;
  endfunction

  // drive one bit; a low value may be cut to three quarters of the bit
  task automatic drive_bit(input logic v, input logic short_low);
    rx_line = v;
    if (short_low && !v) begin
      repeat (bit_clks() * 3 / 4) @(negedge clk);
      rx_line = 1;
      repeat (bit_clks() / 4) @(negedge clk);
    end else begin
      repeat (bit_clks()) @(negedge clk);
    end
  endtask

  task automatic send(input logic [8:0] d, input int nb, input logic stop1,
                      input logic stop2, input logic flip_par);
    logic px = 0;
    drive_bit(1'b0, 1'b0);
    for (int i = 0; i < nb; i++) begin
      px ^= d[i];
      drive_bit(d[i], 1'b0);
    end
    if (par_mode[1]) drive_bit(px ^ par_mode[0] ^ flip_par, 1'b0);
    drive_bit(stop1, 1'b1);
    if (two_stop) drive_bit(stop2, 1'b1);
    rx_line = 1;
    repeat (bit_clks()) @(negedge clk);
  endtask

  task automatic pop();
    rd_en = 1;
    @(negedge clk);
    rd_en = 0;
    @(negedge clk);
  endtask

  task automatic head(input string tag, input logic [8:0] d, input logic fe,
                      input logic pe, input logic ov);
    chk({tag, " valid"}, rx_valid, 1);
    chk({tag, " data"}, {rd_bit9, rd_data}, d);
    chk({tag, " fe"}, rd_frame_err, fe);
    chk({tag, " pe"}, rd_parity_err, pe);
    chk({tag, " ovr"}, rd_overrun, ov);
  endtask

  task automatic t_reset();
    chk("R6 reset valid", rx_valid, 0);
    chk("R10 reset irq", rx_irq, 0);
  endtask

  task automatic t_basic();
    irq_en = 1;
    send(9'h0A5, 8, 1, 1, 0);
    head("R1 R2 8N1", 9'h0A5, 0, 0, 0);
    chk("R10 irq set", rx_irq, 1);
    repeat (40) @(negedge clk);
    chk("R10 irq held", rx_irq, 1);
    pop();
    chk("R10 irq cleared by read", rx_irq, 0);
    chk("R6 empty after read", rx_valid, 0);
    irq_en = 0;
  endtask

  task automatic t_sizes();
    size_sel = 3'd0;
    send(9'h1F3, 5, 1, 1, 0);
    head("R1 five bits", 9'h013, 0, 0, 0);
    pop();
    size_sel = 3'd2;
    send(9'h1D5, 7, 1, 1, 0);
    head("R1 seven bits", 9'h055, 0, 0, 0);
    pop();
    size_sel = 3'd6;
    send(9'h1C3, 9, 1, 1, 0);
    head("R1 nine bits", 9'h1C3, 0, 0, 0);
    pop();
    size_sel = 3'd3;
  endtask

  task automatic t_parity();
    par_mode = 2'd2;
    size_sel = 3'd4;
    send(9'h1C3, 9, 1, 1, 0);
    head("R4 even ok", 9'h1C3, 0, 0, 0);
    pop();
    par_mode = 2'd3;
    size_sel = 3'd3;
    send(9'h03C, 8, 1, 1, 0);
    head("R4 odd ok", 9'h03C, 0, 0, 0);
    pop();
    send(9'h03C, 8, 1, 1, 1);
    head("R4 odd bad", 9'h03C, 0, 1, 0);
    pop();
    par_mode = 2'd0;
  endtask

  task automatic t_stop();
    send(9'h066, 8, 0, 1, 0);
    head("R5 low stop", 9'h066, 1, 0, 0);
    pop();
    chk("R2 no false frame after low stop", rx_valid, 0);
    two_stop = 1;
    send(9'h099, 8, 1, 0, 0);
    head("R5 second stop unchecked", 9'h099, 0, 0, 0);
    pop();
    chk("R2 no false frame after second stop", rx_valid, 0);
    two_stop = 0;
  endtask

  task automatic t_buffer();
    send(9'h011, 8, 1, 1, 0);
    send(9'h022, 8, 1, 1, 0);
    head("R6 first of two", 9'h011, 0, 0, 0);
    send(9'h033, 8, 1, 1, 0);
    head("R7 head after loss", 9'h011, 0, 0, 0);
    pop();
    head("R7 second flagged", 9'h022, 0, 0, 1);
    pop();
    chk("R7 third dropped", rx_valid, 0);
  endtask

  task automatic t_flush();
    send(9'h044, 8, 1, 1, 0);
    chk("R8 stored before flush", rx_valid, 1);
    rx_en = 0;
    repeat (2) @(negedge clk);
    chk("R8 flushed", rx_valid, 0);
    send(9'h055, 8, 1, 1, 0);
    chk("R8 ignored while off", rx_valid, 0);
    rx_en = 1;
    repeat (2) @(negedge clk);
    send(9'h077, 8, 1, 1, 0);
    head("R8 works after enable", 9'h077, 0, 0, 0);
    pop();
  endtask

  task automatic t_filter();
    addr_filter = 1;
    send(9'h012, 8, 0, 1, 0);
    chk("R9 data frame dropped stop", rx_valid, 0);
    send(9'h034, 8, 1, 1, 0);
    head("R9 address by stop", 9'h034, 0, 0, 0);
    pop();
    size_sel = 3'd4;
    send(9'h056, 9, 1, 1, 0);
    chk("R9 data frame dropped ninth", rx_valid, 0);
    send(9'h178, 9, 1, 1, 0);
    head("R9 address by ninth", 9'h178, 0, 0, 0);
    pop();
    size_sel = 3'd3;
    addr_filter = 0;
  endtask

  task automatic t_double();
    dbl_speed = 1;
    send(9'h0C6, 8, 1, 1, 0);
    head("R3 double speed", 9'h0C6, 0, 0, 0);
    pop();
    dbl_speed = 0;
  endtask

  task automatic t_glitch();
    rx_line = 0;
    repeat (3 * TDIV) @(negedge clk);
    rx_line = 1;
    repeat (64 * TDIV) @(negedge clk);
    chk("R2 glitch rejected", rx_valid, 0);
    send(9'h081, 8, 1, 1, 0);
    head("R2 frame after glitch", 9'h081, 0, 0, 0);
    pop();
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic();
    t_sizes();
    t_parity();
    t_stop();
    t_buffer();
    t_flush();
    t_filter();
    t_double();
    t_glitch();
    finish_run();
  end
endmodule